// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Unit

This unit is the host-side control point of a network adapter. The host performs every control action by writing one 16-bit command word. The top five bits of that word select an operation, and the low eleven bits carry the operation's argument. The unit holds several pieces of state: the selected register window, a bank of eight event bits with an interrupt latch, an interrupt mask, a receive address filter mode, and enables for the receive and transmit paths. Writes to any port offset other than the command offset have no effect on this unit.

A status read returns the current window, a busy flag and the eight event bits. Pulses from the packet paths set the event bits. Acknowledge commands clear them. The interrupt line is high while any event bit is both set and unmasked. The receive-reset, transmit-reset and global-reset commands start a fixed busy period, and the unit ignores all commands during that period.

A small sequencer controls the busy period. It has four states: `ST_IDLE`, `ST_GLOBAL` (global reset running), `ST_RXCLR` (receive reset running) and `ST_TXCLR` (transmit reset running). It has two kinds of transition. `start_*` goes from `ST_IDLE` to one of the three busy states when the matching command is accepted; global reset takes priority. `finish` returns from any busy state to `ST_IDLE` when the countdown reaches zero.

Top module: `nic_cmd_status`

## Requirements
- R1: After reset, the status word reads 0x0000 (window 0, not busy, no events). The window port also reads 0, and `irq`, `rx_enable` and `tx_enable` are all low.
- R2: Opcode 1 loads the window from argument bits 2-0. The window then appears in status bits 15-13 and at offset 0xF, where it occupies bits 2-0 and all other bits are zero.
- R3: Each event input sets one status bit on the clock edge at which it is sampled high. The mapping is: adapter failure to bit 1, TX done to bit 2, TX space to bit 3, RX done to bit 4, RX early to bit 5, statistics due to bit 7. Status bits 11-8 always read zero.
- R4: Opcode 13 clears every event bit whose argument bit (7-0) is 1. If an event input is high on the same edge as the acknowledge, the event bit stays set.
- R5: Opcode 12 sets event bit 6.
- R6: Opcode 14 loads the interrupt mask from argument bits 7-0. With window 5 selected, the mask reads back at offset 0xA. `irq` is high while the event bits ANDed with the mask are nonzero.
- R7: Event bit 0 (the latch) becomes set on the same edge on which any unmasked event among bits 7-1 becomes set. It clears only when bit 0 is acknowledged and no unmasked event remains pending. `irq` is never high while the latch is clear.
- R8: Opcode 16 loads the receive filter from argument bits 3-0 (bit 0 individual, bit 1 multicast, bit 2 broadcast, bit 3 promiscuous) and ignores the higher argument bits. With window 5 selected, the filter reads back at offset 0x8.
- R9: Opcodes 4 and 3 turn receive on and off. Opcodes 9 and 10 turn transmit on and off.
- R10: Opcodes 5 and 11 raise `rx_reset` and `tx_reset` respectively, and clear the matching enable. Status bit 12 is set for exactly BUSY_CYCLES cycles.
- R11: Opcode 0 returns the window, mask, filter, enables and all event bits to their reset values, then holds the busy bit for BUSY_CYCLES cycles.
- R12: Every command written while the busy bit is set is ignored.
- R13: Writes to offsets other than 0xE are not decoded as commands. Opcodes that have no defined meaning leave all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 4 | Port offset for both reads and writes |
| host_wdata | input | 16 | Write data; at offset 0xE this is the command word |
| host_rdata | output | 16 | Read data for `host_addr`, combinational |
| ev_adapter_fail | input | 1 | Adapter failure event pulse |
| ev_tx_done | input | 1 | Transmit complete event pulse |
| ev_tx_space | input | 1 | Transmit space available event pulse |
| ev_rx_done | input | 1 | Receive complete event pulse |
| ev_rx_early | input | 1 | Early receive event pulse |
| ev_stats_due | input | 1 | Statistics update event pulse |
| irq | output | 1 | Interrupt request |
| rx_enable | output | 1 | Receive path enable |
| tx_enable | output | 1 | Transmit path enable |
| rx_reset | output | 1 | Receive path reset, high during a receive reset |
| tx_reset | output | 1 | Transmit path reset, high during a transmit reset |
| rx_filter | output | 4 | Receive filter mode |

## Verification
The hardest cases to reach are the ones where two actions land on the same edge. The first is an event pulse arriving on the same edge as an acknowledge of that event. The bench aligns an event input with the command write so that both are sampled together, and expects the bit to survive. The second is a command arriving in the middle of a reset countdown. The bench issues a window select immediately after a receive reset, while the busy bit is known to be set, and confirms from the status port that the window did not move. The same approach checks that the latch stays set when one acknowledged event leaves another unmasked event pending.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 5;
    localparam int ARG_W  = 8;   // argument bits consumed by any command
    localparam int EV_N   = 8;
    localparam int WIN_W  = 3;
    localparam int FILT_W = 4;

    localparam logic [3:0] OFS_STATUS = 4'hE;
    localparam logic [3:0] OFS_WIN    = 4'hF;
    localparam logic [3:0] OFS_MASK   = 4'hA;
    localparam logic [3:0] OFS_FILT   = 4'h8;

    localparam logic [OPC_W-1:0] OP_GRESET = 5'd0;
    localparam logic [OPC_W-1:0] OP_WINSEL = 5'd1;
    localparam logic [OPC_W-1:0] OP_RXOFF  = 5'd3;
    localparam logic [OPC_W-1:0] OP_RXON   = 5'd4;
    localparam logic [OPC_W-1:0] OP_RXRST  = 5'd5;
    localparam logic [OPC_W-1:0] OP_TXON   = 5'd9;
    localparam logic [OPC_W-1:0] OP_TXOFF  = 5'd10;
    localparam logic [OPC_W-1:0] OP_TXRST  = 5'd11;
    localparam logic [OPC_W-1:0] OP_REQINT = 5'd12;
    localparam logic [OPC_W-1:0] OP_ACK    = 5'd13;
    localparam logic [OPC_W-1:0] OP_MASK   = 5'd14;
    localparam logic [OPC_W-1:0] OP_FILT   = 5'd16;

    typedef struct packed {
        logic             greset;
        logic             winsel;
        logic             rx_off;
        logic             rx_on;
        logic             rx_rst;
        logic             tx_on;
        logic             tx_off;
        logic             tx_rst;
        logic             req_int;
        logic             ack;
        logic             set_mask;
        logic             set_filt;
        logic [ARG_W-1:0] arg;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GLOBAL = 2'd1,
        ST_RXCLR  = 2'd2,
        ST_TXCLR  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import nic_cmd_pkg::*;
(
    input  logic              wr,
    input  logic [3:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    output cmd_t              cmd
);

    logic [OPC_W-1:0] opc;
    logic             accept;
    logic             unused_arg_hi;

    assign opc           = wdata[WORD_W-1 -: OPC_W];
    assign unused_arg_hi = ^wdata[WORD_W-OPC_W-1:ARG_W];
    // R13: only the command offset is decoded; R12: nothing while busy
    assign accept        = wr && (addr == OFS_STATUS) && !busy;

    always_comb begin
        cmd     = '0;
        cmd.arg = wdata[ARG_W-1:0];
        if (accept) begin
            case (opc)
                OP_GRESET: cmd.greset   = 1'b1;
                OP_WINSEL: cmd.winsel   = 1'b1;
                OP_RXOFF:  cmd.rx_off   = 1'b1;
                OP_RXON:   cmd.rx_on    = 1'b1;
                OP_RXRST:  cmd.rx_rst   = 1'b1;
                OP_TXON:   cmd.tx_on    = 1'b1;
                OP_TXOFF:  cmd.tx_off   = 1'b1;
                OP_TXRST:  cmd.tx_rst   = 1'b1;
                OP_REQINT: cmd.req_int  = 1'b1;
                OP_ACK:    cmd.ack      = 1'b1;
                OP_MASK:   cmd.set_mask = 1'b1;
                OP_FILT:   cmd.set_filt = 1'b1;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import nic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c_greset,
    input  logic              c_winsel,
    input  logic              c_rx_off,
    input  logic              c_rx_on,
    input  logic              c_rx_rst,
    input  logic              c_tx_on,
    input  logic              c_tx_off,
    input  logic              c_tx_rst,
    input  logic              c_set_mask,
    input  logic              c_set_filt,
    input  logic [ARG_W-1:0]  c_arg,
    output logic [WIN_W-1:0]  win_o,
    output logic [EV_N-1:0]   mask_o,
    output logic [EV_N-1:0]   mask_nx_o,
    output logic [FILT_W-1:0] filt_o,
    output logic              rx_en_o,
    output logic              tx_en_o
);

    logic [WIN_W-1:0]  win_d;
    logic [FILT_W-1:0] filt_d;
    logic              rx_d, tx_d;

    always_comb begin
        win_d     = win_o;
        mask_nx_o = mask_o;
        filt_d    = filt_o;
        rx_d      = rx_en_o;
        tx_d      = tx_en_o;
        if (c_greset) begin
            win_d     = '0;
            mask_nx_o = '0;
            filt_d    = '0;
            rx_d      = 1'b0;
            tx_d      = 1'b0;
        end else begin
            if (c_winsel)            win_d     = c_arg[WIN_W-1:0];
            if (c_set_mask)          mask_nx_o = c_arg[EV_N-1:0];
            if (c_set_filt)          filt_d    = c_arg[FILT_W-1:0];
            if (c_rx_on)             rx_d      = 1'b1;
            if (c_rx_off || c_rx_rst) rx_d     = 1'b0;
            if (c_tx_on)             tx_d      = 1'b1;
            if (c_tx_off || c_tx_rst) tx_d     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_o   <= '0;
            mask_o  <= '0;
            filt_o  <= '0;
            rx_en_o <= 1'b0;
            tx_en_o <= 1'b0;
        end else begin
            win_o   <= win_d;
            mask_o  <= mask_nx_o;
            filt_o  <= filt_d;
            rx_en_o <= rx_d;
            tx_en_o <= tx_d;
        end
    end

    // R2: window moves only on a select or global reset command
    assert_win_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_winsel && !c_greset) |=> $stable(win_o));

    // R8: filter moves only on a filter or global reset command
    assert_filt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_set_filt && !c_greset) |=> $stable(filt_o));

endmodule

// File: rtl/event_bank.sv
module event_bank
    import nic_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             c_greset,
    input  logic             c_ack,
    input  logic             c_req_int,
    input  logic [ARG_W-1:0] c_arg,
    input  logic [EV_N-1:1]  hw_set,
    input  logic [EV_N-1:0]  mask_q,
    input  logic [EV_N-1:0]  mask_nx,
    output logic [EV_N-1:0]  ev_o,
    output logic             irq_o
);

    localparam int REQ_BIT = 6;

    logic [EV_N-1:0] ack_v;
    logic [EV_N-1:1] set_v;
    logic [EV_N-1:0] ev_d;

    assign ack_v = c_ack ? c_arg[EV_N-1:0] : '0;

    always_comb begin
        set_v          = hw_set;
        set_v[REQ_BIT] = hw_set[REQ_BIT] | c_req_int;
    end

    always_comb begin
        if (c_greset) begin
            ev_d = '0;
        end else begin
            ev_d[EV_N-1:1] = (ev_o[EV_N-1:1] & ~ack_v[EV_N-1:1]) | set_v;
            ev_d[0]        = (ev_o[0] & ~ack_v[0])
                           | (|(ev_d[EV_N-1:1] & mask_nx[EV_N-1:1]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_o <= '0;
        else        ev_o <= ev_d;
    end

    assign irq_o = |(ev_o & mask_q);

    // R4: an acknowledged bit with no simultaneous set is clear afterwards
    assert_ack_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ack && !c_greset) |=>
            ((ev_o[EV_N-1:1] & $past(c_arg[EV_N-1:1] & ~set_v)) == '0));

    // R7: the latch covers every unmasked pending event
    assert_latch_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_o[EV_N-1:1] & mask_q[EV_N-1:1])) |-> ev_o[0]);

    // R7: no interrupt while the latch is clear
    assert_irq_needs_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_o[0] |-> !irq_o);

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import nic_cmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic c_greset,
    input  logic c_rx_rst,
    input  logic c_tx_rst,
    output logic busy_o,
    output logic rx_reset_o,
    output logic tx_reset_o
);

    localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    seq_state_e       state, state_d;
    logic [CNT_W-1:0] cnt;

    // next-state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (c_greset)      state_d = ST_GLOBAL;
                else if (c_rx_rst) state_d = ST_RXCLR;
                else if (c_tx_rst) state_d = ST_TXCLR;
            end
            ST_GLOBAL, ST_RXCLR, ST_TXCLR: begin
                if (cnt == '0)     state_d = ST_IDLE;
            end
            default:               state_d = ST_IDLE;
        endcase
    end

    // state register and countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            if (state == ST_IDLE && state_d != ST_IDLE) cnt <= CNT_LOAD;
            else if (state != ST_IDLE && cnt != '0)      cnt <= cnt - 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy_o     = 1'b0;
        rx_reset_o = 1'b0;
        tx_reset_o = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_GLOBAL: busy_o = 1'b1;
            ST_RXCLR:  begin busy_o = 1'b1; rx_reset_o = 1'b1; end
            ST_TXCLR:  begin busy_o = 1'b1; tx_reset_o = 1'b1; end
            default:   ;
        endcase
    end

    // R10: a finished countdown always returns to idle
    assert_busy_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && cnt == '0) |=> (state == ST_IDLE));

    // R10: at most one path reset at a time
    assert_one_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_reset_o, tx_reset_o}));

endmodule

// File: rtl/nic_cmd_status.sv
module nic_cmd_status
    import nic_cmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 4,
    parameter int DIAG_WIN    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [3:0]        host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              ev_adapter_fail,
    input  logic              ev_tx_done,
    input  logic              ev_tx_space,
    input  logic              ev_rx_done,
    input  logic              ev_rx_early,
    input  logic              ev_stats_due,
    output logic              irq,
    output logic              rx_enable,
    output logic              tx_enable,
    output logic              rx_reset,
    output logic              tx_reset,
    output logic [FILT_W-1:0] rx_filter
);

    localparam logic [WIN_W-1:0] DIAG_SEL = WIN_W'(DIAG_WIN);

    cmd_t              cmd;
    logic              busy;
    logic [WIN_W-1:0]  win_q;
    logic [EV_N-1:0]   mask_q, mask_nx, ev_q;
    logic [EV_N-1:1]   hw_set;
    logic [WORD_W-1:0] status_w;

    assign hw_set = {ev_stats_due, 1'b0, ev_rx_early, ev_rx_done,
                     ev_tx_space, ev_tx_done, ev_adapter_fail};

    cmd_decode u_dec (
        .wr    (host_wr),
        .addr  (host_addr),
        .wdata (host_wdata),
        .busy  (busy),
        .cmd   (cmd)
    );

    cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .c_greset   (cmd.greset),
        .c_winsel   (cmd.winsel),
        .c_rx_off   (cmd.rx_off),
        .c_rx_on    (cmd.rx_on),
        .c_rx_rst   (cmd.rx_rst),
        .c_tx_on    (cmd.tx_on),
        .c_tx_off   (cmd.tx_off),
        .c_tx_rst   (cmd.tx_rst),
        .c_set_mask (cmd.set_mask),
        .c_set_filt (cmd.set_filt),
        .c_arg      (cmd.arg),
        .win_o      (win_q),
        .mask_o     (mask_q),
        .mask_nx_o  (mask_nx),
        .filt_o     (rx_filter),
        .rx_en_o    (rx_enable),
        .tx_en_o    (tx_enable)
    );

    event_bank u_ev (
        .clk       (clk),
        .rst_n     (rst_n),
        .c_greset  (cmd.greset),
        .c_ack     (cmd.ack),
        .c_req_int (cmd.req_int),
        .c_arg     (cmd.arg),
        .hw_set    (hw_set),
        .mask_q    (mask_q),
        .mask_nx   (mask_nx),
        .ev_o      (ev_q),
        .irq_o     (irq)
    );

    seq_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .c_greset   (cmd.greset),
        .c_rx_rst   (cmd.rx_rst),
        .c_tx_rst   (cmd.tx_rst),
        .busy_o     (busy),
        .rx_reset_o (rx_reset),
        .tx_reset_o (tx_reset)
    );

    assign status_w = {win_q, busy, 4'b0000, ev_q};

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_STATUS: host_rdata = status_w;
            OFS_WIN:    host_rdata = {{(WORD_W-WIN_W){1'b0}}, win_q};
            OFS_MASK:   if (win_q == DIAG_SEL)
                            host_rdata = {{(WORD_W-EV_N){1'b0}}, mask_q};
            OFS_FILT:   if (win_q == DIAG_SEL)
                            host_rdata = {{(WORD_W-FILT_W){1'b0}}, rx_filter};
            default:    host_rdata = '0;
        endcase
    end

    // R12: configuration is frozen while a reset countdown runs
    assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(win_q) && $stable(mask_q) && $stable(rx_filter)));

    // R10: a path in reset is never enabled
    assert_reset_disables_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_reset |-> !rx_enable) and (tx_reset |-> !tx_enable));

endmodule

// File: tb/sim_nic_cmd_status.sv
`timescale 1ns/1ps
module sim_nic_cmd_status;

    localparam int BUSY = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = 4'hE;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        ev_adapter_fail = 0, ev_tx_done = 0, ev_tx_space = 0;
    logic        ev_rx_done = 0, ev_rx_early = 0, ev_stats_due = 0;
    logic        irq, rx_enable, tx_enable, rx_reset, tx_reset;
    logic [3:0]  rx_filter;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    nic_cmd_status #(.BUSY_CYCLES(BUSY), .DIAG_WIN(5)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ev_adapter_fail(ev_adapter_fail), .ev_tx_done(ev_tx_done),
        .ev_tx_space(ev_tx_space), .ev_rx_done(ev_rx_done),
        .ev_rx_early(ev_rx_early), .ev_stats_due(ev_stats_due),
        .irq(irq), .rx_enable(rx_enable), .tx_enable(tx_enable),
        .rx_reset(rx_reset), .tx_reset(tx_reset), .rx_filter(rx_filter)
    );

    // {opcode, argument, expected status, expected irq}
    localparam logic [32:0] VEC [10] = '{
        {5'd1,  11'h003, 16'h6000, 1'b0},  // R2 window 3
        {5'd1,  11'h005, 16'hA000, 1'b0},  // R2 window 5
        {5'd12, 11'h000, 16'hA040, 1'b0},  // R5 masked off: no latch
        {5'd13, 11'h040, 16'hA000, 1'b0},  // R4 ack bit 6
        {5'd14, 11'h044, 16'hA000, 1'b0},  // R6 mask bits 2,6
        {5'd12, 11'h000, 16'hA041, 1'b1},  // R7 latch with event
        {5'd13, 11'h040, 16'hA001, 1'b0},  // R7 latch kept without ack
        {5'd13, 11'h001, 16'hA000, 1'b0},  // R7 latch acked
        {5'd7,  11'h7FF, 16'hA000, 1'b0},  // R13 undefined opcode
        {5'd1,  11'h000, 16'h0000, 1'b0}   // R2 back to window 0
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_port(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_addr = 4'hE;
    endtask

    task automatic cmd(input logic [4:0] op, input logic [10:0] arg);
        wr_port(4'hE, {op, arg});
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
        host_addr = 4'hE;
        #1;
    endtask

    task automatic wait_idle();
        while (host_rdata[12]) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] r;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'hE, r); chk("R1 status", r, 16'h0000);
        rd(4'hF, r); chk("R1 window port", r, 16'h0000);
        chk("R1 irq/rx/tx", {13'd0, irq, rx_enable, tx_enable}, 16'h0000);

        // table walk: R2 R4 R5 R6 R7 R13
        for (int i = 0; i < 10; i++) begin
            cmd(VEC[i][32:28], VEC[i][27:17]);
            rd(4'hE, r);
            chk($sformatf("R2/R4/R5/R6/R7/R13 vector %0d status", i), r, VEC[i][16:1]);
            chk($sformatf("R6/R7 vector %0d irq", i), {15'd0, irq}, {15'd0, VEC[i][0]});
        end

        // R3 event mapping, mask is 0x44
        @(negedge clk); ev_tx_done = 1; @(negedge clk); ev_tx_done = 0;
        rd(4'hE, r); chk("R3 tx done bit 2 with latch R7", r, 16'h0005);
        chk("R6 irq on unmasked event", {15'd0, irq}, 16'h0001);
        cmd(5'd13, 11'h005);
        rd(4'hE, r); chk("R4 ack 0x05", r, 16'h0000);
        @(negedge clk);
        ev_adapter_fail = 1; ev_tx_space = 1; ev_rx_early = 1; ev_stats_due = 1;
        @(negedge clk);
        ev_adapter_fail = 0; ev_tx_space = 0; ev_rx_early = 0; ev_stats_due = 0;
        rd(4'hE, r); chk("R3 bits 1,3,5,7 masked off", r, 16'h00AA);
        chk("R6 irq low when masked", {15'd0, irq}, 16'h0000);
        cmd(5'd13, 11'h0FF);
        rd(4'hE, r); chk("R4 ack all", r, 16'h0000);

        // R4 set wins over ack on the same edge
        @(negedge clk);
        ev_rx_done = 1; host_wr = 1; host_addr = 4'hE; host_wdata = {5'd13, 11'h010};
        @(negedge clk);
        ev_rx_done = 0; host_wr = 0;
        rd(4'hE, r); chk("R4 simultaneous set survives ack", r, 16'h0010);
        cmd(5'd13, 11'h010);
        rd(4'hE, r); chk("R4 later ack clears", r, 16'h0000);

        // R8 filter and R6 mask readback in window 5
        cmd(5'd1, 11'h005);
        cmd(5'd16, 11'h7FB);
        chk("R8 filter output", {12'd0, rx_filter}, 16'h000B);
        rd(4'h8, r); chk("R8 filter readback", r, 16'h000B);
        rd(4'hA, r); chk("R6 mask readback", r, 16'h0044);
        rd(4'hF, r); chk("R2 window port", r, 16'h0005);

        // R9 enables
        cmd(5'd4, 11'h0); chk("R9 rx on", {15'd0, rx_enable}, 16'h0001);
        cmd(5'd9, 11'h0); chk("R9 tx on", {15'd0, tx_enable}, 16'h0001);
        cmd(5'd3, 11'h0); chk("R9 rx off", {15'd0, rx_enable}, 16'h0000);
        cmd(5'd10, 11'h0); chk("R9 tx off", {15'd0, tx_enable}, 16'h0000);

        // R10 transmit reset length
        cmd(5'd9, 11'h0);
        cmd(5'd11, 11'h0);
        rd(4'hE, r); chk("R10 busy bit", r, 16'hB000);
        chk("R10 tx reset, tx off", {14'd0, tx_reset, tx_enable}, 16'h0002);
        n = 1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (tx_reset) n++;
        end
        chk("R10 busy length", 16'(n), 16'(BUSY));

        // R12 command during receive reset ignored
        cmd(5'd4, 11'h0);
        cmd(5'd5, 11'h0);
        chk("R10 rx reset, rx off", {14'd0, rx_reset, rx_enable}, 16'h0002);
        cmd(5'd1, 11'h002);
        wait_idle();
        rd(4'hF, r); chk("R12 window unchanged", r, 16'h0005);

        // R13 write to another offset is not a command
        wr_port(4'h2, {5'd1, 11'h006});
        rd(4'hF, r); chk("R13 other offset ignored", r, 16'h0005);

        // R11 global reset
        cmd(5'd14, 11'h0FF);
        cmd(5'd4, 11'h0);
        cmd(5'd12, 11'h0);
        rd(4'hE, r); chk("R11 pre state", r, 16'hA041);
        cmd(5'd0, 11'h0);
        rd(4'hE, r); chk("R11 busy, cleared", r, 16'h1000);
        chk("R11 outputs cleared", {11'd0, irq, rx_enable, rx_filter}, 16'h0000);
        wait_idle();
        rd(4'hE, r); chk("R11 idle after busy", r, 16'h0000);
        cmd(5'd1, 11'h005);
        rd(4'hA, r); chk("R11 mask cleared", r, 16'h0000);
        rd(4'h8, r); chk("R11 filter cleared", r, 16'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule